// File: doc/BRIEF.md
# ADC Trigger and Gate Conditioner

This block turns an external start condition into the two control signals that the ADC pacer logic consumes. The condition comes either from a digital trigger pin or from a pair of comparator outputs that watch an analog trigger input against a high and a low threshold. All three raw inputs are asynchronous and are resynchronised before use. The conditioned level can be inverted. It can then be used either as a gate level that enables conversions while it is active, or as an edge source that yields one single-cycle start pulse.

Edge operation needs software to arm it. Each arm write permits exactly one trigger pulse. Arming is dropped whenever the function is disabled. In the analog path, the two threshold enables and a hysteresis bit choose one of these conditions: above the high threshold, below the low threshold, inside the window between them, or a Schmitt-style level that is set by the high threshold and cleared by the low one.

Top module: `trig_gate_cond`

## Requirements
- R1: After reset `trig_o` and `gate_o` are 0.
- R2: With `en_i`=0, `gate_o` stays 0 and `trig_o` never pulses, whatever the inputs and `arm_wr_i` do.
- R3: In level mode (`edge_mode_i`=0, `en_i`=1) with the digital source (`src_ana_i`=0), `gate_o` follows the conditioned level. A change on `ext_trig_i` reaches `gate_o` after the second rising clock edge, and not after the first.
- R4: `pol_i`=1 inverts the conditioned level. The gate is then active while the source is low, and edges are detected on the source's falling transition.
- R5: In edge mode, when armed, a 0-to-1 transition of the conditioned level gives `trig_o`=1 for exactly one cycle. For the digital source the pulse appears after the third rising edge that follows the input change.
- R6: A trigger is honoured only after a `arm_wr_i` pulse taken while `en_i`=1. Firing disarms the block, so later edges give no pulse until the next arm. Arming is cleared while `en_i`=0.
- R7: In edge mode `gate_o` stays 0.
- R8: With the analog source and only `hi_en_i`=1, the level is `cmp_hi_i` (input above the high threshold). The analog path adds one register, so it has one cycle more latency than the digital path.
- R9: With the analog source and only `lo_en_i`=1, the level is the inverse of `cmp_lo_i` (input below the low threshold).
- R10: With both enables set and `hyst_i`=0, the level is 1 only inside the window: `cmp_lo_i`=1 and `cmp_hi_i`=0.
- R11: With both enables set and `hyst_i`=1, the level is set while `cmp_hi_i`=1, cleared while `cmp_lo_i`=0, and held when the input lies between the thresholds.
- R12: With the analog source and neither enable set, the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enables the external trigger/gate function |
| edge_mode_i | input | 1 | 1 = edge trigger, 0 = level gate |
| pol_i | input | 1 | 1 = inverted sense (falling edge / low level) |
| src_ana_i | input | 1 | 1 = analog comparator source, 0 = digital pin |
| hi_en_i | input | 1 | Enables the high-threshold comparator |
| lo_en_i | input | 1 | Enables the low-threshold comparator |
| hyst_i | input | 1 | Hysteresis mode when both comparators are enabled |
| arm_wr_i | input | 1 | Single-cycle arm write |
| ext_trig_i | input | 1 | Asynchronous digital trigger pin |
| cmp_hi_i | input | 1 | Asynchronous comparator: input above high threshold |
| cmp_lo_i | input | 1 | Asynchronous comparator: input above low threshold |
| trig_o | output | 1 | Single-cycle trigger pulse |
| gate_o | output | 1 | Gate level for the pacer |

## Verification
The bench builds the block with its default two-stage synchroniser. This makes the exact latencies of R3, R5 and R8 observable: two rising edges to the gate for the pin, one more for the analog path, and one more for the trigger pulse. Every analog mode is driven through combinations of comparator values, including the in-between hold state of hysteresis from both sides. Arm handling is probed by firing, re-edging while disarmed, re-arming with the level already high, and arming while disabled.

// File: rtl/trig_cond_pkg.sv
`timescale 1ns/1ps
package trig_cond_pkg;
  // analog condition selected by {lo_en, hi_en}
  typedef enum logic [1:0] {
    ANA_OFF    = 2'b00,
    ANA_ABOVE  = 2'b01,
    ANA_BELOW  = 2'b10,
    ANA_WINDOW = 2'b11
  } ana_sel_e;
endpackage

// File: rtl/tcg_sync.sv
`timescale 1ns/1ps
module tcg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tcg_analog.sv
`timescale 1ns/1ps
module tcg_analog
  import trig_cond_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_s_i,
  input  logic lo_s_i,
  input  logic hi_en_i,
  input  logic lo_en_i,
  input  logic hyst_i,
  output logic lvl_o
);
  ana_sel_e sel;
  logic     lvl_q, lvl_d;

  assign sel = ana_sel_e'({lo_en_i, hi_en_i});

  always_comb begin
    unique case (sel)
      ANA_ABOVE:  lvl_d = hi_s_i;
      ANA_BELOW:  lvl_d = ~lo_s_i;
      // hysteresis: set above hi, hold between, clear below lo
      ANA_WINDOW: lvl_d = hyst_i ? (hi_s_i | (lvl_q & lo_s_i))
                                 : (lo_s_i & ~hi_s_i);
      default:    lvl_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/tcg_fire.sv
`timescale 1ns/1ps
module tcg_fire (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic arm_wr_i,
  input  logic cond_i,
  output logic trig_o,
  output logic gate_o
);
  logic prev_q, armed_q, trig_q, fire, armed_d;

  assign fire = en_i & edge_mode_i & armed_q & cond_i & ~prev_q;

  always_comb begin
    if (!en_i)        armed_d = 1'b0;
    else if (arm_wr_i) armed_d = 1'b1;
    else if (fire)     armed_d = 1'b0;
    else               armed_d = armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      prev_q  <= cond_i;
      armed_q <= armed_d;
      trig_q  <= fire;
    end
  end

  assign trig_o = trig_q;
  assign gate_o = en_i & ~edge_mode_i & cond_i;
endmodule

// File: rtl/trig_gate_cond.sv
`timescale 1ns/1ps
module trig_gate_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  input  logic src_ana_i,
  input  logic hi_en_i,
  input  logic lo_en_i,
  input  logic hyst_i,
  input  logic arm_wr_i,
  input  logic ext_trig_i,
  input  logic cmp_hi_i,
  input  logic cmp_lo_i,
  output logic trig_o,
  output logic gate_o
);
  localparam int unsigned NIN = 3;

  logic [NIN-1:0] raw, syn;
  logic ext_s, cmp_hi_s, cmp_lo_s, ana_lvl, cond;

  assign raw = {cmp_lo_i, cmp_hi_i, ext_trig_i};

  tcg_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign ext_s    = syn[0];
  assign cmp_hi_s = syn[1];
  assign cmp_lo_s = syn[2];

  tcg_analog u_ana (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hi_s_i (cmp_hi_s),
    .lo_s_i (cmp_lo_s),
    .hi_en_i(hi_en_i),
    .lo_en_i(lo_en_i),
    .hyst_i (hyst_i),
    .lvl_o  (ana_lvl)
  );

  assign cond = (src_ana_i ? ana_lvl : ext_s) ^ pol_i;

  tcg_fire u_fire (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .edge_mode_i(edge_mode_i),
    .arm_wr_i   (arm_wr_i),
    .cond_i     (cond),
    .trig_o     (trig_o),
    .gate_o     (gate_o)
  );
endmodule

// File: rtl/tcg_checker.sv
`timescale 1ns/1ps
module tcg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic edge_mode_i,
  input logic hi_en_i,
  input logic lo_en_i,
  input logic hyst_i,
  input logic cmp_hi_s,
  input logic cmp_lo_s,
  input logic ana_lvl,
  input logic trig_o
);
  logic cfg_h;
  assign cfg_h = hyst_i & hi_en_i & lo_en_i;

  a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r2_off_no_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !trig_o);

  a_r7_trig_from_edge_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(edge_mode_i) && $past(en_i)));

  a_r11_hyst_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_h && $past(cfg_h) && $past(cmp_hi_s)) |-> ana_lvl);

  a_r11_hyst_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_h && $past(cfg_h) && !$past(cmp_lo_s) && !$past(cmp_hi_s)) |-> !ana_lvl);
endmodule

bind trig_gate_cond tcg_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .edge_mode_i(edge_mode_i),
  .hi_en_i    (hi_en_i),
  .lo_en_i    (lo_en_i),
  .hyst_i     (hyst_i),
  .cmp_hi_s   (cmp_hi_s),
  .cmp_lo_s   (cmp_lo_s),
  .ana_lvl    (ana_lvl),
  .trig_o     (trig_o)
);

// File: tb/tb_trig_gate_cond.sv
`timescale 1ns/1ps
module tb_trig_gate_cond;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, edge_mode_i = 0, pol_i = 0, src_ana_i = 0;
  logic hi_en_i = 0, lo_en_i = 0, hyst_i = 0, arm_wr_i = 0;
  logic ext_trig_i = 0, cmp_hi_i = 0, cmp_lo_i = 0;
  logic trig_o, gate_o;

  int checks = 0, errors = 0, trig_cnt = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  trig_gate_cond dut (.*);

  always @(posedge clk_i) if (rst_ni && trig_o) trig_cnt++;

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    arm_wr_i = 1; step(1); arm_wr_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 trig", trig_o, 0);
    chk("R1 gate", gate_o, 0);
  endtask

  task automatic t_level();
    en_i = 1; edge_mode_i = 0; src_ana_i = 0; pol_i = 0;
    ext_trig_i = 1; step(1);
    chk("R3 gate after one edge", gate_o, 0);
    step(1);
    chk("R3 gate after two edges", gate_o, 1);
    ext_trig_i = 0; step(2);
    chk("R3 gate low", gate_o, 0);
  endtask

  task automatic t_pol();
    pol_i = 1; step(2);
    chk("R4 inverted gate active low", gate_o, 1);
    ext_trig_i = 1; step(2);
    chk("R4 inverted gate high input", gate_o, 0);
    pol_i = 0; ext_trig_i = 0; step(3);
  endtask

  task automatic t_disable();
    int c0 = trig_cnt;
    en_i = 0; ext_trig_i = 1; step(3);
    chk("R2 gate off", gate_o, 0);
    edge_mode_i = 1; ext_trig_i = 0; step(3);
    arm(); ext_trig_i = 1; step(5);
    chk("R2 no trig", trig_cnt - c0, 0);
    en_i = 1; ext_trig_i = 0; step(3);
    ext_trig_i = 1; step(5);
    chk("R6 arm dropped while disabled", trig_cnt - c0, 0);
    ext_trig_i = 0; step(3);
  endtask

  task automatic t_edge();
    int c0 = trig_cnt;
    arm(); ext_trig_i = 1; step(2);
    chk("R5 no early pulse", trig_o, 0);
    step(1);
    chk("R5 pulse", trig_o, 1);
    chk("R7 gate off in edge mode", gate_o, 0);
    step(1);
    chk("R5 pulse width", trig_o, 0);
    ext_trig_i = 0; step(3);
    ext_trig_i = 1; step(5);
    chk("R6 disarmed after fire", trig_cnt - c0, 1);
    arm(); step(4);
    chk("R6 no pulse on arm with level high", trig_cnt - c0, 1);
    ext_trig_i = 0; step(3); ext_trig_i = 1; step(5);
    chk("R6 re-armed fires", trig_cnt - c0, 2);
    pol_i = 1; step(3); arm(); ext_trig_i = 0; step(5);
    chk("R4 falling edge fires", trig_cnt - c0, 3);
    pol_i = 0; edge_mode_i = 0; step(3);
  endtask

  task automatic ana(logic hi, logic lo, int exp, string req);
    cmp_hi_i = hi; cmp_lo_i = lo; step(3);
    chk(req, gate_o, exp);
  endtask

  task automatic t_analog();
    int c0;
    src_ana_i = 1; edge_mode_i = 0;
    hi_en_i = 1; lo_en_i = 0;
    cmp_hi_i = 1; cmp_lo_i = 1; step(2);
    chk("R8 analog extra cycle", gate_o, 0);
    step(1);
    chk("R8 above hi", gate_o, 1);
    ana(0, 1, 0, "R8 below hi");
    hi_en_i = 0; lo_en_i = 1;
    ana(0, 1, 0, "R9 above lo");
    ana(0, 0, 1, "R9 below lo");
    hi_en_i = 1;
    ana(0, 1, 1, "R10 inside window");
    ana(1, 1, 0, "R10 above window");
    ana(0, 0, 0, "R10 below window");
    hi_en_i = 0; lo_en_i = 0;
    ana(0, 1, 0, "R12 off mid");
    ana(1, 1, 0, "R12 off high");
    hi_en_i = 1; lo_en_i = 1; hyst_i = 1;
    ana(0, 0, 0, "R11 below");
    ana(0, 1, 0, "R11 between from below");
    ana(1, 1, 1, "R11 above");
    ana(0, 1, 1, "R11 between held");
    ana(0, 0, 0, "R11 cleared");
    ana(0, 1, 0, "R11 between held low");
    hyst_i = 0; lo_en_i = 0; cmp_hi_i = 0; step(3);
    c0 = trig_cnt; edge_mode_i = 1; arm();
    cmp_hi_i = 1; step(3);
    chk("R8 analog edge not yet", trig_o, 0);
    step(1);
    chk("R8 analog edge pulse", trig_o, 1);
    step(2);
    chk("R8 analog edge count", trig_cnt - c0, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_ni = 1; step(2);
    t_reset();
    t_level();
    t_pol();
    t_disable();
    edge_mode_i = 1; en_i = 1;
    t_edge();
    t_analog();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule